// File: doc/BRIEF.md
# Transmit Packet FIFO with In-Line Length Entries

This block sits between a processor write path and a framed streaming output. Software writes a packet as a series of 32-bit data words. It then writes the packet's byte count to a length port. The length write closes the packet. The length value is stored in the same memory as the data, directly behind the last word of the packet. Data words become visible to the output side only once their length has been stored. Storing the length also frees the length port for the next packet.

The output side reads whole packets in the order they were closed. Each packet is sent as `ceil(L/4)` beats. Start-of-frame marks the first beat and end-of-frame marks the last. On the last beat a two-bit remainder code says how many of its bytes are valid.

A free-entry count lets software confirm there is room for a packet plus its length entry before it starts writing. A bad length write does three things: it raises a one-cycle error flag, it discards the packet's words, and it gives their space back.

Top module: `txpkt_fifo`

## Requirements
- R1: Data words that have no length written yet are never presented: `tx_valid` stays low. `free_words` equals DEPTH minus the entries held, and each data word and each accepted length takes one entry. After reset `free_words` is DEPTH and `tx_valid`, `tx_sof`, `tx_eof` and `len_err` are low.
- R2: An accepted length of L bytes sends the words of that packet as exactly `ceil(L/4)` beats, in the order they were written.
- R3: `tx_sof` is high only on the first beat of a frame and `tx_eof` only on its last beat. Both are low while `tx_valid` is low.
- R4: On the last beat `tx_rem` equals `(L-1) mod 4`, so code 0 means 1 valid byte and code 3 means 4 valid bytes. On every other beat `tx_rem` is 3.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_sof`, `tx_eof` and `tx_rem` hold their values. A beat advances only when both are high.
- R6: The length is taken from bits [10:0] of `len_wdata`. Bits [31:11] are ignored.
- R7: A length below 13 or above 4*(DEPTH-2) bytes is rejected. On the next cycle `len_err` is high for one cycle, the packet's words are discarded, `free_words` returns to its value from before the packet, and no beat is sent.
- R8: A length write is also rejected in the same way as R7 when no data words have been written since the last accepted length, or when the FIFO is full.
- R9: A data write is ignored while the FIFO is full, and it is also ignored in the same cycle as a length write.
- R10: Several closed packets queue up and are sent one after another in the order their lengths were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | 32 | Data word |
| len_we | input | 1 | Length write strobe; closes the current packet |
| len_wdata | input | 32 | Length register value; byte count in bits [10:0] |
| free_words | output | $clog2(DEPTH)+1 | Free FIFO entries |
| len_err | output | 1 | One-cycle pulse after a rejected length write |
| tx_valid | output | 1 | Output beat valid |
| tx_ready | input | 1 | Output beat accepted by the sink |
| tx_data | output | 32 | Output beat data |
| tx_sof | output | 1 | First beat of a frame |
| tx_eof | output | 1 | Last beat of a frame |
| tx_rem | output | 2 | Valid bytes minus one on the last beat |

## Verification
The bench builds the block with DEPTH set to 16. With that depth the largest legal packet is 14 words (56 bytes). This lets the bench reach the upper length bound, the byte just past it and a completely full memory within a few dozen writes. The bench also covers several things at the ports:
- the 13-byte minimum;
- all four remainder codes;
- frames queued back to back under a toggling ready;
- a long stall;
- discarded packets whose space must come back.

// File: rtl/txpf_pkg.sv
package txpf_pkg;
  localparam int TXPF_W = 32;

  typedef struct packed {
    logic              is_len;
    logic [TXPF_W-1:0] word;
  } txpf_entry_t;
endpackage

// File: rtl/txpf_store.sv
// Entry memory with three write-side pointers (write, packet base, commit)
// and a one-entry show-ahead read stage. DEPTH must be a power of two.
module txpf_store
  import txpf_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_data,
  input  logic [TXPF_W-1:0] data_in,
  input  logic              push_len,
  input  logic [TXPF_W-1:0] len_in,
  input  logic              drop,
  input  logic              q_pop,
  output logic              q_valid,
  output txpf_entry_t       q_entry,
  output logic              full,
  output logic              has_pending,
  output logic [PW-1:0]     free_cnt
);
  txpf_entry_t mem [DEPTH];

  logic [PW-1:0] wr_ptr, base_ptr, com_ptr, rd_ptr;
  logic [PW-1:0] used;
  logic          push, fetch;
  txpf_entry_t   wr_entry;

  assign used        = wr_ptr - rd_ptr;
  assign full        = (used == PW'(DEPTH));
  assign free_cnt    = PW'(DEPTH) - used;
  assign has_pending = (wr_ptr != base_ptr);
  assign push        = push_data | push_len;
  assign fetch       = (rd_ptr != com_ptr) && (!q_valid || q_pop);

  always_comb begin
    wr_entry.is_len = push_len;
    wr_entry.word   = push_len ? len_in : data_in;
  end

  // memory array: no reset, single write and registered read
  always_ff @(posedge clk) begin
    if (push)  mem[wr_ptr[AW-1:0]] <= wr_entry;
    if (fetch) q_entry <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      base_ptr <= '0;
      com_ptr  <= '0;
    end else if (drop) begin
      wr_ptr <= base_ptr;
    end else if (push) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (push_len) begin
        base_ptr <= wr_ptr + 1'b1;
        com_ptr  <= wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr  <= '0;
      q_valid <= 1'b0;
    end else if (fetch) begin
      rd_ptr  <= rd_ptr + 1'b1;
      q_valid <= 1'b1;
    end else if (q_pop) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txpf_lencheck.sv
// Decides whether a length write closes the packet or discards it.
module txpf_lencheck #(
  parameter int LEN_W     = 11,
  parameter int MIN_BYTES = 13,
  parameter int MAX_BYTES = 2040
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic             has_data,
  input  logic             full,
  output logic             accept,
  output logic             reject,
  output logic             len_err
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_BYTES);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_BYTES);

  logic in_range;

  assign in_range = (len_bytes >= MIN_L) && (len_bytes <= MAX_L);
  assign accept   = len_we && in_range && has_data && !full;
  assign reject   = len_we && !accept;

  always_ff @(posedge clk) begin
    if (rst) len_err <= 1'b0;
    else     len_err <= reject;
  end
endmodule

// File: rtl/txpf_framer.sv
// Holds one data word and looks at the next entry: when that entry is a
// length, the held word is the last beat of its frame.
module txpf_framer
  import txpf_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_valid,
  input  txpf_entry_t       q_entry,
  output logic              q_pop,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [TXPF_W-1:0] tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic [1:0]        tx_rem
);
  logic             cur_valid;
  logic             sof_pend;
  logic             fire, load;
  logic [LEN_W-1:0] len_m1;

  assign len_m1   = q_entry.word[LEN_W-1:0] - LEN_W'(1);
  assign tx_valid = cur_valid && q_valid;
  assign tx_eof   = tx_valid && q_entry.is_len;
  assign tx_sof   = tx_valid && sof_pend;
  assign tx_rem   = tx_eof ? len_m1[1:0] : 2'b11;
  assign fire     = tx_valid && tx_ready;
  assign load     = q_valid && !q_entry.is_len && (!cur_valid || fire);
  assign q_pop    = load || (fire && q_entry.is_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_valid <= 1'b0;
      sof_pend  <= 1'b1;
    end else begin
      if (load)      cur_valid <= 1'b1;
      else if (fire) cur_valid <= 1'b0;
      if (fire)      sof_pend  <= tx_eof;
    end
  end

  always_ff @(posedge clk) begin
    if (load) tx_data <= q_entry.word;
  end
endmodule

// File: rtl/txpkt_fifo.sv
module txpkt_fifo
  import txpf_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int LEN_W     = 11,
  parameter int MIN_BYTES = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dat_we,
  input  logic [TXPF_W-1:0]      dat_wdata,
  input  logic                   len_we,
  input  logic [TXPF_W-1:0]      len_wdata,
  output logic [$clog2(DEPTH):0] free_words,
  output logic                   len_err,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic [TXPF_W-1:0]      tx_data,
  output logic                   tx_sof,
  output logic                   tx_eof,
  output logic [1:0]             tx_rem
);
  localparam int MAX_WORDS = DEPTH - 2;
  localparam int MAX_BYTES = 4 * MAX_WORDS;

  logic        full, has_pending, accept, reject, q_valid, q_pop;
  logic        push_data;
  txpf_entry_t q_entry;
  logic        len_hi_unused;

  assign push_data     = dat_we && !len_we && !full;
  assign len_hi_unused = ^len_wdata[TXPF_W-1:LEN_W];

  txpf_lencheck #(
    .LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES), .MAX_BYTES(MAX_BYTES)
  ) u_chk_len (
    .clk(clk), .rst(rst), .len_we(len_we),
    .len_bytes(len_wdata[LEN_W-1:0]), .has_data(has_pending),
    .full(full), .accept(accept), .reject(reject), .len_err(len_err)
  );

  txpf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_data(push_data), .data_in(dat_wdata),
    .push_len(accept), .len_in(len_wdata), .drop(reject), .q_pop(q_pop),
    .q_valid(q_valid), .q_entry(q_entry), .full(full),
    .has_pending(has_pending), .free_cnt(free_words)
  );

  txpf_framer #(.LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst(rst), .q_valid(q_valid), .q_entry(q_entry),
    .q_pop(q_pop), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_rem(tx_rem)
  );
endmodule

// File: rtl/txpkt_fifo_chk.sv
module txpkt_fifo_chk #(
  parameter int DEPTH = 512
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   len_we,
  input logic                   len_err,
  input logic [$clog2(DEPTH):0] free_words,
  input logic                   tx_valid,
  input logic                   tx_ready,
  input logic [31:0]            tx_data,
  input logic                   tx_sof,
  input logic                   tx_eof,
  input logic [1:0]             tx_rem
);
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
      $stable(tx_sof) && $stable(tx_eof) && $stable(tx_rem)));

  a_r1_free_bound: assert property (@(posedge clk) disable iff (rst)
    free_words <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r7_err_after_len: assert property (@(posedge clk) disable iff (rst)
    len_err |-> $past(len_we));

  a_r3_no_sof_midframe: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !tx_eof) |=> !tx_sof);

  a_r3_marks_need_valid: assert property (@(posedge clk) disable iff (rst)
    !tx_valid |-> (!tx_sof && !tx_eof));
endmodule

bind txpkt_fifo txpkt_fifo_chk #(.DEPTH(DEPTH)) u_prop (
  .clk(clk), .rst(rst), .len_we(len_we), .len_err(len_err),
  .free_words(free_words), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_rem(tx_rem)
);

// File: tb/sim_txpkt_fifo.sv
module sim_txpkt_fifo;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int FW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dat_we = 1'b0, len_we = 1'b0, tx_ready = 1'b1;
  logic [31:0]   dat_wdata = '0, len_wdata = '0;
  logic [FW-1:0] free_words;
  logic          len_err, tx_valid, tx_sof, tx_eof;
  logic [31:0]   tx_data;
  logic [1:0]    tx_rem;

  int checks = 0, errors = 0;
  int rdy_mode = 0;

  logic [31:0] exp_d [64];
  logic [3:0]  exp_m [64];
  logic [31:0] got_d [64];
  logic [3:0]  got_m [64];
  int exp_n = 0, got_n = 0;

  txpkt_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .free_words(free_words),
    .len_err(len_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_rem(tx_rem)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk); #1;
      case (rdy_mode)
        0:       tx_ready = 1'b1;
        1:       tx_ready = ~tx_ready;
        default: tx_ready = 1'b0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready && got_n < 64) begin
      got_d[got_n] = tx_data;
      got_m[got_n] = {tx_sof, tx_eof, tx_rem};
      got_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic exp_pkt(input int nw, input int len, input logic [31:0] base);
    for (int i = 0; i < nw; i++) begin
      exp_d[exp_n] = base + i;
      exp_m[exp_n] = {(i == 0), (i == nw-1), (i == nw-1) ? 2'((len-1) % 4) : 2'd3};
      exp_n++;
    end
  endtask

  task automatic wr_word(input logic [31:0] d);
    @(posedge clk); #1;
    dat_we = 1'b1; dat_wdata = d;
    @(posedge clk); #1;
    dat_we = 1'b0;
  endtask

  task automatic wr_len(input logic [31:0] l);
    @(posedge clk); #1;
    len_we = 1'b1; len_wdata = l;
    @(posedge clk); #1;
    len_we = 1'b0;
  endtask

  task automatic wr_words(input int nw, input logic [31:0] base);
    for (int i = 0; i < nw; i++) wr_word(base + i);
  endtask

  task automatic drain(input string req);
    int t = 0;
    while (got_n < exp_n && t < 3000) begin
      @(posedge clk); t++;
    end
    repeat (12) @(posedge clk);
    chk(got_n == exp_n, {req, " beat count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
      chk(got_m[i] == exp_m[i], {req, " sof/eof/rem"}, got_m[i], exp_m[i]);
    end
    got_n = 0; exp_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(free_words == FW'(DEPTH), "R1 reset free", free_words, DEPTH);
    chk(!tx_valid && !tx_sof && !tx_eof, "R1 reset stream idle", tx_valid, 0);
    chk(!len_err, "R1 reset err", len_err, 0);
  endtask

  task automatic t_hold_then_send();
    wr_words(4, 32'h100);
    repeat (6) @(posedge clk);
    #1;
    chk(!tx_valid, "R1 no beat before length", tx_valid, 0);
    chk(free_words == FW'(DEPTH-4), "R1 free after data", free_words, DEPTH-4);
    exp_pkt(4, 16, 32'h100);
    wr_len(16);
    chk(!len_err, "R2 legal length no error", len_err, 0);
    drain("R2 R3 R4 single frame");
    chk(free_words == FW'(DEPTH), "R1 free after drain", free_words, DEPTH);
  endtask

  task automatic t_queue_remainders();
    rdy_mode = 1;
    wr_words(4, 32'h200); wr_len(13); exp_pkt(4, 13, 32'h200);
    wr_words(4, 32'h300); wr_len(14); exp_pkt(4, 14, 32'h300);
    wr_words(4, 32'h400); wr_len(15); exp_pkt(4, 15, 32'h400);
    wr_words(6, 32'h500); wr_len(21); exp_pkt(6, 21, 32'h500);
    drain("R10 R4 R5 queued frames");
    rdy_mode = 0;
  endtask

  task automatic t_max_stall();
    rdy_mode = 2;
    wr_words(14, 32'h600);
    wr_len(56);
    chk(!len_err, "R2 max length accepted", len_err, 0);
    exp_pkt(14, 56, 32'h600);
    repeat (20) @(posedge clk);
    #1;
    chk(got_n == 0, "R5 no advance while not ready", got_n, 0);
    chk(tx_valid && tx_sof && tx_data == 32'h600, "R5 head beat waiting", tx_data, 32'h600);
    rdy_mode = 0;
    drain("R2 R5 max frame");
  endtask

  task automatic t_errors();
    wr_words(4, 32'h700);
    wr_len(12);
    chk(len_err, "R7 short length error", len_err, 1);
    chk(free_words == FW'(DEPTH), "R7 space returned", free_words, DEPTH);
    @(posedge clk); #1;
    chk(!len_err, "R7 error is one cycle", len_err, 0);
    wr_words(14, 32'h800);
    wr_len(57);
    chk(len_err, "R7 long length error", len_err, 1);
    chk(free_words == FW'(DEPTH), "R7 long discard space", free_words, DEPTH);
    wr_len(16);
    chk(len_err, "R8 length without data", len_err, 1);
    drain("R7 R8 nothing sent");
  endtask

  task automatic t_upper_bits();
    wr_words(4, 32'h900);
    wr_len(32'hFFFF_F800 | 32'd16);
    chk(!len_err, "R6 upper bits ignored", len_err, 0);
    exp_pkt(4, 16, 32'h900);
    drain("R6 frame from low field");
  endtask

  task automatic t_full();
    wr_words(DEPTH, 32'hA00);
    chk(free_words == 0, "R9 memory full", free_words, 0);
    wr_word(32'hDEAD);
    chk(free_words == 0, "R9 write when full ignored", free_words, 0);
    wr_len(20);
    chk(len_err, "R8 length when full rejected", len_err, 1);
    chk(free_words == FW'(DEPTH), "R8 full discard space", free_words, DEPTH);
    drain("R8 R9 nothing sent");
  endtask

  task automatic t_same_cycle();
    wr_words(4, 32'hB00);
    @(posedge clk); #1;
    dat_we = 1'b1; dat_wdata = 32'hBEEF;
    len_we = 1'b1; len_wdata = 32'd16;
    @(posedge clk); #1;
    dat_we = 1'b0; len_we = 1'b0;
    chk(!len_err, "R9 same-cycle length accepted", len_err, 0);
    exp_pkt(4, 16, 32'hB00);
    drain("R9 same-cycle data dropped");
    chk(free_words == FW'(DEPTH), "R9 no stray entry", free_words, DEPTH);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    t_hold_then_send();
    t_queue_remainders();
    t_max_stall();
    t_errors();
    t_upper_bits();
    t_full();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule